// File: doc/BRIEF.md
# Directory-Coherent Cache Controller

This block is the cache controller for one processor in a machine where memory coherence is kept by a home directory, not by a shared bus. It holds a small direct-mapped cache of one-word blocks. Each line holds a tag, a data word and one of three states: Invalid, Shared or Exclusive. A processor load or store that hits completes in the cycle it is presented. Any other access sends a point-to-point request to the home node and holds the processor until the home's data reply has filled the line. Before a new block displaces a dirty block, the controller sends a write-back of the old block.

The controller also serves the requests that the directory addresses to it. An invalidate removes a Shared copy. A fetch returns the dirty word of an Exclusive line and keeps a Shared copy. A fetch-and-invalidate returns the word and removes the copy. Every directory message is handled in the cycle it arrives. Because of this, requests that come in while a miss is outstanding are served in arrival order, ahead of the reply that ends the miss.

Outgoing messages leave from a registered port, one cycle after the event that causes them. Each message carries a kind, this processor's number, a block address and a data word.

Top module: `dir_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid, net_valid is 0 and no access completes until a miss has been served.
- R2: A read whose block is present in Shared or Exclusive state raises cpu_done in the same cycle, with cpu_rdata equal to the line's word, and sends no message.
- R3: A write to a block held Exclusive raises cpu_done in the same cycle, sends no message, and replaces the line's word, so a later read returns the new value.
- R4: A read to a block that is not present sends a read miss (net_kind 0, net_src = PROC_ID, the full address, data 0). This message is visible two cycles after the request is first presented. When a data reply for that address arrives, the line becomes Shared with the reply's word, and the read completes in the next cycle.
- R5: A write to a block that is not held Exclusive, including a block held Shared, sends a write miss (net_kind 1). After the reply the line is Exclusive and holds the processor's word, not the reply's.
- R6: When a miss maps to a line that holds a different block in Exclusive state, a write-back (net_kind 2, old block address, old word) is sent first. The miss follows in the next cycle.
- R7: An incoming invalidate (dir_kind 0) for a block held Shared makes the line Invalid. For any block not held, it has no effect.
- R8: An incoming fetch (dir_kind 1) for a block held Exclusive sends a data return (net_kind 2 is not used; net_kind 3) with the line's word in the next cycle, and leaves the line Shared.
- R9: An incoming fetch-and-invalidate (dir_kind 2) for a block held Exclusive sends a data return (net_kind 3) with the word in the next cycle, and leaves the line Invalid.
- R10: In a cycle where a directory message arrives, no access completes and no processor-side message is started. The deferred work proceeds in a later cycle.
- R11: Directory requests that arrive while a miss is outstanding are served in arrival order. A data reply (dir_kind 3) ends the miss only if its address equals the pending address; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W | Block address of the access |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Access completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_done |
| dir_valid | input | 1 | Message from the directory present |
| dir_kind | input | 2 | 0 invalidate, 1 fetch, 2 fetch-and-invalidate, 3 data reply |
| dir_addr | input | ADDR_W | Block address of the directory message |
| dir_data | input | DATA_W | Word carried by a data reply |
| net_valid | output | 1 | Outgoing message present |
| net_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back, 3 fetch data return |
| net_src | output | PID_W | Number of this processor |
| net_addr | output | ADDR_W | Block address of the outgoing message |
| net_data | output | DATA_W | Word carried by the outgoing message |

## Verification
Two events can fall in the same cycle: a processor access that would hit or start a miss, and an arriving directory message that touches the same line store and the single output port. The bench provokes this by queuing directory messages so that they land in the very cycle a request is first presented, and in the cycles just after a miss has gone out. It then judges each cycle against a behavioural model that withholds completion and processor-side messages whenever a directory message is present. The result is checked through access latency, through the message order on the network port, and through the data later read back.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        OUT_RDMISS = 2'd0,
        OUT_WRMISS = 2'd1,
        OUT_WRBACK = 2'd2,
        OUT_FDATA  = 2'd3
    } out_kind_e;

    typedef enum logic [1:0] {
        IN_INVAL    = 2'd0,
        IN_FETCH    = 2'd1,
        IN_FETCHINV = 2'd2,
        IN_REPLY    = 2'd3
    } in_kind_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_WB   = 2'd1,
        CS_REQ  = 2'd2,
        CS_WAIT = 2'd3
    } ctl_st_e;

    function automatic logic holds_copy(line_st_e s);
        return s != LN_INV;
    endfunction

endpackage

// File: rtl/dcc_lines.sv
module dcc_lines
    import dcc_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  a_idx,
    output line_st_e          a_st,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output line_st_e          b_st,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              w_en,
    input  logic [IDX_W-1:0]  w_idx,
    input  line_st_e          w_st,
    input  logic              w_load,
    input  logic [TAG_W-1:0]  w_tag,
    input  logic [DATA_W-1:0] w_data
);

    line_st_e          st_q  [LINES];
    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i] <= LN_INV;
            end else if (w_en && w_idx == IDX_W'(i)) begin
                st_q[i] <= w_st;
                if (w_load) begin
                    tag_q[i] <= w_tag;
                    dat_q[i] <= w_data;
                end
            end
        end
    end

    assign a_st   = st_q[a_idx];
    assign a_tag  = tag_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_st   = st_q[b_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_data = dat_q[b_idx];

endmodule

// File: rtl/dcc_miss_seq.sv
module dcc_miss_seq
    import dcc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  line_st_e          vic_st,
    input  logic [TAG_W-1:0]  vic_tag,
    input  logic [DATA_W-1:0] vic_data,
    input  logic              dir_valid,
    input  in_kind_e          dir_kind,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [DATA_W-1:0] dir_data,
    output logic              idle,
    output logic [ADDR_W-1:0] pend_addr,
    output logic              emit,
    output out_kind_e         emit_kind,
    output logic [ADDR_W-1:0] emit_addr,
    output logic [DATA_W-1:0] emit_data,
    output logic              lw_en,
    output line_st_e          lw_st,
    output logic              lw_load,
    output logic [DATA_W-1:0] lw_data
);

    ctl_st_e           st_q;
    logic              pwe_q;
    logic [DATA_W-1:0] pwd_q;
    logic              reply_ok;

    assign idle     = (st_q == CS_IDLE);
    assign reply_ok = (st_q == CS_WAIT) && dir_valid &&
                      (dir_kind == IN_REPLY) && (dir_addr == pend_addr);

    always_comb begin
        emit      = 1'b0;
        emit_kind = OUT_RDMISS;
        emit_addr = pend_addr;
        emit_data = '0;
        lw_en     = 1'b0;
        lw_st     = LN_INV;
        lw_load   = 1'b0;
        lw_data   = dir_data;
        unique case (st_q)
            CS_WB: begin
                if (!dir_valid && vic_st == LN_EXC) begin
                    emit      = 1'b1;
                    emit_kind = OUT_WRBACK;
                    emit_addr = {vic_tag, pend_addr[IDX_W-1:0]};
                    emit_data = vic_data;
                    lw_en     = 1'b1;
                end
            end
            CS_REQ: begin
                if (!dir_valid) begin
                    emit      = 1'b1;
                    emit_kind = pwe_q ? OUT_WRMISS : OUT_RDMISS;
                    lw_en     = 1'b1;
                end
            end
            CS_WAIT: begin
                if (reply_ok) begin
                    lw_en   = 1'b1;
                    lw_load = 1'b1;
                    lw_st   = pwe_q ? LN_EXC : LN_SHR;
                    lw_data = pwe_q ? pwd_q : dir_data;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= CS_IDLE;
            pwe_q     <= 1'b0;
            pwd_q     <= '0;
            pend_addr <= '0;
        end else begin
            unique case (st_q)
                CS_IDLE: if (start) begin
                    pend_addr <= cpu_addr;
                    pwe_q     <= cpu_we;
                    pwd_q     <= cpu_wdata;
                    st_q      <= (vic_st == LN_EXC && vic_tag != cpu_addr[ADDR_W-1:IDX_W])
                                 ? CS_WB : CS_REQ;
                end
                CS_WB:   if (!dir_valid) st_q <= CS_REQ;
                CS_REQ:  if (!dir_valid) st_q <= CS_WAIT;
                CS_WAIT: if (reply_ok)   st_q <= CS_IDLE;
                default: st_q <= CS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dir_cache_ctrl.sv
module dir_cache_ctrl
    import dcc_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int LINES   = 4,
    parameter int PID_W   = 2,
    parameter int PROC_ID = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              dir_valid,
    input  logic [1:0]        dir_kind,
    input  logic [ADDR_W-1:0] dir_addr,
    input  logic [DATA_W-1:0] dir_data,
    output logic              net_valid,
    output logic [1:0]        net_kind,
    output logic [PID_W-1:0]  net_src,
    output logic [ADDR_W-1:0] net_addr,
    output logic [DATA_W-1:0] net_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic              v;
        out_kind_e         kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } net_msg_t;

    in_kind_e          dkind;
    logic              seq_idle;
    logic [ADDR_W-1:0] pend_addr;
    logic [IDX_W-1:0]  a_idx;
    line_st_e          a_st, b_st;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              cpu_hit, sn_match, sn_we, sn_emit;
    line_st_e          sn_st;
    logic              f_emit, f_we, f_load;
    out_kind_e         f_kind;
    logic [ADDR_W-1:0] f_addr;
    logic [DATA_W-1:0] f_data, f_wdata;
    line_st_e          f_st;
    logic              w_en, w_load;
    logic [IDX_W-1:0]  w_idx;
    line_st_e          w_st;
    logic [TAG_W-1:0]  w_tag;
    logic [DATA_W-1:0] w_data;
    net_msg_t          out_d, out_q;

    assign dkind = in_kind_e'(dir_kind);
    assign a_idx = seq_idle ? cpu_addr[IDX_W-1:0] : pend_addr[IDX_W-1:0];

    dcc_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_lines (
        .clk    (clk),
        .rst    (rst),
        .a_idx  (a_idx),
        .a_st   (a_st),
        .a_tag  (a_tag),
        .a_data (a_data),
        .b_idx  (dir_addr[IDX_W-1:0]),
        .b_st   (b_st),
        .b_tag  (b_tag),
        .b_data (b_data),
        .w_en   (w_en),
        .w_idx  (w_idx),
        .w_st   (w_st),
        .w_load (w_load),
        .w_tag  (w_tag),
        .w_data (w_data)
    );

    // processor side lookup
    assign cpu_hit   = cpu_req && seq_idle && holds_copy(a_st) &&
                       (a_tag == cpu_addr[ADDR_W-1:IDX_W]) &&
                       (!cpu_we || a_st == LN_EXC);
    assign cpu_done  = cpu_hit && !dir_valid;
    assign cpu_rdata = a_data;

    dcc_miss_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cpu_req && !cpu_hit && !dir_valid),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .vic_st    (a_st),
        .vic_tag   (a_tag),
        .vic_data  (a_data),
        .dir_valid (dir_valid),
        .dir_kind  (dkind),
        .dir_addr  (dir_addr),
        .dir_data  (dir_data),
        .idle      (seq_idle),
        .pend_addr (pend_addr),
        .emit      (f_emit),
        .emit_kind (f_kind),
        .emit_addr (f_addr),
        .emit_data (f_data),
        .lw_en     (f_we),
        .lw_st     (f_st),
        .lw_load   (f_load),
        .lw_data   (f_wdata)
    );

    // directory request service
    assign sn_match = dir_valid && holds_copy(b_st) && (b_tag == dir_addr[ADDR_W-1:IDX_W]);

    always_comb begin
        sn_we   = 1'b0;
        sn_emit = 1'b0;
        sn_st   = b_st;
        unique case (dkind)
            IN_INVAL: if (sn_match && b_st == LN_SHR) begin
                sn_we = 1'b1;
                sn_st = LN_INV;
            end
            IN_FETCH: if (sn_match && b_st == LN_EXC) begin
                sn_we   = 1'b1;
                sn_emit = 1'b1;
                sn_st   = LN_SHR;
            end
            IN_FETCHINV: if (sn_match && b_st == LN_EXC) begin
                sn_we   = 1'b1;
                sn_emit = 1'b1;
                sn_st   = LN_INV;
            end
            default: ;
        endcase
    end

    // single line write port; sources never coincide
    always_comb begin
        w_en   = 1'b0;
        w_idx  = cpu_addr[IDX_W-1:0];
        w_st   = LN_EXC;
        w_load = 1'b0;
        w_tag  = cpu_addr[ADDR_W-1:IDX_W];
        w_data = cpu_wdata;
        if (sn_we) begin
            w_en  = 1'b1;
            w_idx = dir_addr[IDX_W-1:0];
            w_st  = sn_st;
        end else if (f_we) begin
            w_en   = 1'b1;
            w_idx  = pend_addr[IDX_W-1:0];
            w_st   = f_st;
            w_load = f_load;
            w_tag  = pend_addr[ADDR_W-1:IDX_W];
            w_data = f_wdata;
        end else if (cpu_done && cpu_we) begin
            w_en   = 1'b1;
            w_load = 1'b1;
        end
    end

    // outgoing message register
    always_comb begin
        if (sn_emit) begin
            out_d = '{v: 1'b1, kind: OUT_FDATA, addr: dir_addr, data: b_data};
        end else begin
            out_d = '{v: f_emit, kind: f_kind, addr: f_addr, data: f_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign net_valid = out_q.v;
    assign net_kind  = out_q.kind;
    assign net_addr  = out_q.addr;
    assign net_data  = out_q.data;
    assign net_src   = PID_W'(PROC_ID);

endmodule

// File: rtl/dcc_chk.sv
module dcc_chk #(
    parameter int PID_W   = 2,
    parameter int PROC_ID = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cpu_req,
    input logic             cpu_done,
    input logic             dir_valid,
    input logic [1:0]       dir_kind,
    input logic             net_valid,
    input logic [1:0]       net_kind,
    input logic [PID_W-1:0] net_src
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!net_valid && !cpu_done));

    // R10
    dir_blocks_done_chk: assert property (@(posedge clk) disable iff (rst)
        dir_valid |-> !cpu_done);

    // R2
    done_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_done |-> cpu_req);

    // R4
    miss_src_chk: assert property (@(posedge clk) disable iff (rst)
        (net_valid && net_kind <= 2'd1) |-> (net_src == PID_W'(PROC_ID)));

    // R8
    fdata_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (net_valid && net_kind == 2'd3) |->
            ($past(dir_valid) && ($past(dir_kind) == 2'd1 || $past(dir_kind) == 2'd2)));

endmodule

bind dir_cache_ctrl dcc_chk #(.PID_W(PID_W), .PROC_ID(PROC_ID)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_done  (cpu_done),
    .dir_valid (dir_valid),
    .dir_kind  (dir_kind),
    .net_valid (net_valid),
    .net_kind  (net_kind),
    .net_src   (net_src)
);

// File: tb/test_dir_cache_ctrl.sv
`timescale 1ns/1ps
module test_dir_cache_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NL = 4;
    localparam int PW = 2;
    localparam int PID = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_done;
    logic [DW-1:0] cpu_rdata;
    logic          dir_valid = 1'b0;
    logic [1:0]    dir_kind = '0;
    logic [AW-1:0] dir_addr = '0;
    logic [DW-1:0] dir_data = '0;
    logic          net_valid;
    logic [1:0]    net_kind;
    logic [PW-1:0] net_src;
    logic [AW-1:0] net_addr;
    logic [DW-1:0] net_data;

    always #4 clk = ~clk;

    dir_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .PID_W(PW), .PROC_ID(PID)) i_dir_cache_ctrl (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_addr(dir_addr), .dir_data(dir_data),
        .net_valid(net_valid), .net_kind(net_kind), .net_src(net_src),
        .net_addr(net_addr), .net_data(net_data)
    );

    typedef struct {int k; int a; int d;} dmsg_t;
    dmsg_t dq[$];
    dmsg_t late[$];

    int checks = 0, fails = 0;
    string cur = "R1";
    int hmem [256];

    // behavioural model: 0 idle, 1 write-back pending, 2 miss pending, 3 waiting reply
    int m_st [NL];
    int m_tag[NL];
    int m_dat[NL];
    int ph = 0, pa = 0, pwe = 0, pwd = 0;
    int e_nv = 0, e_nk = 0, e_na = 0, e_nd = 0;
    bit seen_done;
    int seen_rd;

    task automatic chk(bit ok, string r, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    task automatic cyc();
        int ca, ci, ct, dv, dk, da, dd, nv, nk, na, nd, pi, di;
        bit ed, match;
        if (dq.size() > 0) begin
            dmsg_t m = dq.pop_front();
            dir_valid = 1'b1; dir_kind = m.k[1:0]; dir_addr = m.a[AW-1:0]; dir_data = m.d[DW-1:0];
        end else begin
            dir_valid = 1'b0;
        end
        #1;
        ca = int'(cpu_addr); ci = ca % NL; ct = ca / NL;
        dv = dir_valid; dk = dir_kind; da = dir_addr; dd = dir_data;
        ed = (ph == 0) && !dv && cpu_req && m_st[ci] != 0 && m_tag[ci] == ct &&
             (!cpu_we || m_st[ci] == 2);
        chk(cpu_done == ed, cur, "cpu_done", cpu_done, ed);
        if (ed) chk(int'(cpu_rdata) == m_dat[ci], cur, "cpu_rdata", cpu_rdata, m_dat[ci]);
        chk(net_valid == e_nv[0], cur, "net_valid", net_valid, e_nv);
        if (e_nv != 0 && net_valid)
            chk(int'(net_kind) == e_nk && int'(net_src) == PID && int'(net_addr) == e_na &&
                int'(net_data) == e_nd, cur, "net msg {kind,addr,data}",
                {net_kind, net_addr, net_data}, (e_nk << 24) | (e_na << 16) | e_nd);
        seen_done = cpu_done;
        seen_rd = int'(cpu_rdata);
        // home responder, driven by the expected traffic
        if (e_nv != 0) begin
            if (e_nk == 2 || e_nk == 3) hmem[e_na] = e_nd;
            else begin
                while (late.size() > 0) dq.push_back(late.pop_front());
                dq.push_back('{3, e_na, hmem[e_na]});
            end
        end
        // model update
        nv = 0; nk = 0; na = 0; nd = 0;
        pi = pa % NL;
        if (dv != 0) begin
            if (dk == 3) begin
                if (ph == 3 && da == pa) begin
                    m_st[pi] = pwe ? 2 : 1; m_tag[pi] = pa / NL;
                    m_dat[pi] = pwe ? pwd : dd; ph = 0;
                end
            end else begin
                di = da % NL;
                match = m_st[di] != 0 && m_tag[di] == da / NL;
                if (dk == 0 && match && m_st[di] == 1) m_st[di] = 0;
                if ((dk == 1 || dk == 2) && match && m_st[di] == 2) begin
                    nv = 1; nk = 3; na = da; nd = m_dat[di];
                    m_st[di] = (dk == 1) ? 1 : 0;
                end
            end
        end else begin
            case (ph)
                0: if (cpu_req) begin
                    if (ed) begin
                        if (cpu_we) m_dat[ci] = int'(cpu_wdata);
                    end else begin
                        pa = ca; pwe = cpu_we; pwd = int'(cpu_wdata);
                        ph = (m_st[ci] == 2 && m_tag[ci] != ct) ? 1 : 2;
                    end
                end
                1: begin
                    if (m_st[pi] == 2) begin
                        nv = 1; nk = 2; na = m_tag[pi] * NL + pi; nd = m_dat[pi]; m_st[pi] = 0;
                    end
                    ph = 2;
                end
                2: begin
                    nv = 1; nk = pwe ? 1 : 0; na = pa; nd = 0; m_st[pi] = 0; ph = 3;
                end
                default: ;
            endcase
        end
        e_nv = nv; e_nk = nk; e_na = na; e_nd = nd;
        @(negedge clk);
    endtask

    task automatic access(bit we, int a, int d, string r, output int n, output int rd);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a[AW-1:0]; cpu_wdata = d[DW-1:0];
        cur = r; n = 0;
        do begin
            n++;
            cyc();
        end while (!seen_done && n < 60);
        rd = seen_rd;
        cpu_req = 1'b0;
        if (!seen_done) chk(0, r, "access never completed", n, 0);
    endtask

    task automatic idle(int n, string r);
        cur = r;
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin
        #1_200_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, rd;
        for (int i = 0; i < 256; i++) hmem[i] = (i * 37 + 11) & 16'hFFFF;
        for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, a read to a cold cache neither completes nor emits
        cpu_req = 1'b1; cpu_addr = 8'h00; cpu_we = 1'b0;
        #1;
        chk(net_valid == 1'b0, "R1", "net_valid after reset", net_valid, 0);
        chk(cpu_done == 1'b0, "R1", "cpu_done on cold line", cpu_done, 0);
        cpu_req = 1'b0;
        @(negedge clk);

        // R4: read miss then fill Shared
        access(0, 'h10, 0, "R4", n, rd);
        chk(n == 5, "R4", "read miss latency", n, 5);
        chk(rd == hmem['h10], "R4", "filled word", rd, hmem['h10]);
        // R2: read hit
        access(0, 'h10, 0, "R2", n, rd);
        chk(n == 1, "R2", "read hit latency", n, 1);
        // R5: write to a Shared block is a write miss
        access(1, 'h10, 'hAAAA, "R5", n, rd);
        chk(n == 5, "R5", "upgrade latency", n, 5);
        access(0, 'h10, 0, "R5", n, rd);
        chk(rd == 'hAAAA, "R5", "line holds cpu word", rd, 'hAAAA);
        // R3: write hit on Exclusive
        access(1, 'h10, 'h5555, "R3", n, rd);
        chk(n == 1, "R3", "write hit latency", n, 1);
        access(0, 'h10, 0, "R3", n, rd);
        chk(rd == 'h5555 && n == 1, "R3", "read after write hit", rd, 'h5555);
        // R8: fetch drops to Shared and returns data
        dq.push_back('{1, 'h10, 0});
        idle(3, "R8");
        chk(hmem['h10] == 'h5555, "R8", "returned word", hmem['h10], 'h5555);
        access(0, 'h10, 0, "R8", n, rd);
        chk(n == 1, "R8", "Shared copy kept", n, 1);
        access(1, 'h10, 'h1234, "R8", n, rd);
        chk(n == 5, "R8", "write after fetch misses", n, 5);
        // R9: fetch-and-invalidate
        dq.push_back('{2, 'h10, 0});
        idle(3, "R9");
        chk(hmem['h10] == 'h1234, "R9", "returned word", hmem['h10], 'h1234);
        access(0, 'h10, 0, "R9", n, rd);
        chk(n == 5 && rd == 'h1234, "R9", "line invalid then refilled", n, 5);
        // R6: dirty victim written back first
        access(1, 'h21, 'h7777, "R6", n, rd);
        access(0, 'h25, 0, "R6", n, rd);
        chk(n == 6, "R6", "write-back plus miss latency", n, 6);
        chk(hmem['h21] == 'h7777, "R6", "victim word at home", hmem['h21], 'h7777);
        chk(rd == hmem['h25], "R6", "new block word", rd, hmem['h25]);
        // R7: invalidate only affects a matching Shared copy
        access(0, 'h32, 0, "R7", n, rd);
        dq.push_back('{0, 'h36, 0});
        idle(2, "R7");
        access(0, 'h32, 0, "R7", n, rd);
        chk(n == 1, "R7", "unrelated invalidate ignored", n, 1);
        dq.push_back('{0, 'h32, 0});
        idle(2, "R7");
        access(0, 'h32, 0, "R7", n, rd);
        chk(n == 5, "R7", "invalidated line misses", n, 5);
        // R10: directory traffic in the same cycle as a hit or a miss start
        dq.push_back('{0, 'h3E, 0});
        access(0, 'h32, 0, "R10", n, rd);
        chk(n == 2, "R10", "hit deferred one cycle", n, 2);
        dq.push_back('{0, 'h00, 0});
        dq.push_back('{0, 'h00, 0});
        access(0, 'h44, 0, "R10", n, rd);
        chk(n == 7, "R10", "miss start deferred", n, 7);
        // R11: requests during an outstanding miss, stray reply ignored
        access(1, 'h13, 'h4444, "R11", n, rd);
        late.push_back('{1, 'h13, 0});
        late.push_back('{3, 'h99, 'hDEAD});
        late.push_back('{0, 'h31, 0});
        access(0, 'h31, 0, "R11", n, rd);
        chk(n == 8, "R11", "miss latency with queued requests", n, 8);
        chk(hmem['h13] == 'h4444, "R11", "fetch served during miss", hmem['h13], 'h4444);
        chk(rd == hmem['h31], "R11", "stray reply not consumed", rd, hmem['h31]);
        idle(3, "R11");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule